// File: doc/BRIEF.md
# Single-Photon Diode Active Quench Controller

This block drives one bidirectional pad wired to the cathode of a single-photon avalanche diode. It uses three pad conditions: driven high, driven low and released (high-impedance). It watches the pad through the input buffer. A logic-low read while the pad is released means the diode has avalanched. The block then pulls the pad low to quench the diode, holds it there for a programmable time to suppress afterpulses, drives it high to recharge the node, and releases it again. It re-arms only after the released node has read high for a programmable settling window. Each detected event produces one single-cycle trigger pulse for downstream counters or timers.

The three windows (hold-off, recharge and settling) are given as clock-cycle counts on input ports. A count of zero behaves as one cycle. The count for a window is compared live while that window runs, so software should change the values only while the block is armed. The pad input passes through a synchroniser before it is used. The pad controls and the trigger all come straight from flops.

Top module: `spad_quench_ctrl`

## Requirements
- R1: While rst_n is low, pad_oe=1, pad_out=1 and trigger=0. After release, the pad stays driven high for max(recharge_cycles,1) cycles and is then released (pad_oe=0).
- R2: The pad input passes through a two-flop synchroniser. A low on pad_in while the block is armed raises trigger at the third rising clock edge after the change, and a low lasting one full clock cycle is enough.
- R3: At the edge where trigger rises, pad_oe becomes 1 and pad_out becomes 0 (quench), and both change together with trigger.
- R4: trigger is high for exactly one cycle per event. It does not fire again until the block has been re-armed, even if the pad stays low.
- R5: The pad is driven low (pad_oe=1, pad_out=0) for exactly max(hold_cycles,1) cycles, counting the trigger cycle.
- R6: After hold-off, the pad is driven high (pad_oe=1, pad_out=1) for exactly max(recharge_cycles,1) cycles and is then released (pad_oe=0).
- R7: A low read while the pad is released but the block is not yet armed causes no trigger, and the pad stays released.
- R8: The block arms only after the synchronised input has read high on max(settle_cycles,1) consecutive rising edges while released. Any low read restarts the window. If the pad rises and falls again after fewer than max(settle_cycles,1) cycles of high, no trigger is produced. A drop after exactly that many cycles of high is detected.
- R9: A zero in hold_cycles, recharge_cycles or settle_cycles acts as a one-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Pad input buffer read (asynchronous) |
| hold_cycles | input | CNT_W | Hold-off length in cycles (0 acts as 1) |
| recharge_cycles | input | CNT_W | Recharge length in cycles (0 acts as 1) |
| settle_cycles | input | CNT_W | Stable-high window before re-arming (0 acts as 1) |
| pad_oe | output | 1 | Pad output enable (0 = high-impedance) |
| pad_out | output | 1 | Pad output value when enabled |
| trigger | output | 1 | One-cycle pulse per detected avalanche |

## Verification
The bench models the pad node: while driven, the node follows pad_out, and while released it follows a level set by the test. It measures the detection latency and the exact lengths of the drive-low and drive-high windows. A timer off by one would show up as a window one cycle long or short, and a missing synchroniser stage as a latency of two. The settling window is probed at its exact threshold: a drop one cycle before arming must be ignored, and a drop on the first armed cycle must be caught. This exposes a design that arms on the first high read or counts one cycle too many. A pad held low through recharge and the released phase checks that the trigger cannot re-fire and the driver stays off. Zero counts check that a window does not collapse to nothing or wrap to a full counter range.

// File: rtl/spq_pkg.sv
`timescale 1ns/1ps
package spq_pkg;

  // Phase order is behavioural: armed -> quench -> recharge -> settle -> armed
  typedef enum logic [1:0] {
    PH_SETTLE   = 2'd0,  // released, waiting for a stable high
    PH_ARMED    = 2'd1,  // released, watching for a low read
    PH_QUENCH   = 2'd2,  // driven low for the hold-off window
    PH_RECHARGE = 2'd3   // driven high to restore the node
  } phase_t;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drive_t;

  // Pad condition requested by each phase
  function automatic pad_drive_t drive_for(input phase_t ph);
    pad_drive_t d;
    d.oe  = (ph == PH_QUENCH) || (ph == PH_RECHARGE);
    d.val = (ph == PH_RECHARGE);
    return d;
  endfunction

endpackage

// File: rtl/spq_sync.sv
`timescale 1ns/1ps
module spq_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] chain;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];

endmodule

// File: rtl/spq_timer.sv
`timescale 1ns/1ps
module spq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Index of the final cycle of a window; a zero limit behaves as one
  function automatic logic [CNT_W-1:0] final_index(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? '0 : lim - 1'b1;
  endfunction

  logic [CNT_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  elapsed <= '0;
    else if (restart)            elapsed <= '0;
    else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

  assign done = (elapsed >= final_index(limit));

endmodule

// File: rtl/spq_fsm.sv
`timescale 1ns/1ps
module spq_fsm #(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sense_hi,
  input  logic                 win_done,
  input  logic [CNT_W-1:0]     hold_cycles,
  input  logic [CNT_W-1:0]     recharge_cycles,
  input  logic [CNT_W-1:0]     settle_cycles,
  output logic                 win_restart,
  output logic [CNT_W-1:0]     win_limit,
  output spq_pkg::phase_t      phase,
  output logic                 pad_oe,
  output logic                 pad_out,
  output logic                 trigger
);
  import spq_pkg::*;

  phase_t     phase_nx;
  pad_drive_t drive_nx;
  logic       avalanche;   // low read seen while armed

  always_comb begin
    phase_nx    = phase;
    win_restart = 1'b0;
    avalanche   = 1'b0;
    unique case (phase)
      PH_SETTLE: begin
        if (!sense_hi) begin
          win_restart = 1'b1;
        end else if (win_done) begin
          phase_nx    = PH_ARMED;
          win_restart = 1'b1;
        end
      end
      PH_ARMED: begin
        win_restart = 1'b1;
        if (!sense_hi) begin
          phase_nx  = PH_QUENCH;
          avalanche = 1'b1;
        end
      end
      PH_QUENCH: begin
        if (win_done) begin
          phase_nx    = PH_RECHARGE;
          win_restart = 1'b1;
        end
      end
      PH_RECHARGE: begin
        if (win_done) begin
          phase_nx    = PH_SETTLE;
          win_restart = 1'b1;
        end
      end
      default: begin
        phase_nx    = PH_RECHARGE;
        win_restart = 1'b1;
      end
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_QUENCH:   win_limit = hold_cycles;
      PH_RECHARGE: win_limit = recharge_cycles;
      default:     win_limit = settle_cycles;
    endcase
  end

  assign drive_nx = drive_for(phase_nx);

  // Power-up: node is charged first, so reset lands in the recharge phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_RECHARGE;
      pad_oe  <= 1'b1;
      pad_out <= 1'b1;
      trigger <= 1'b0;
    end else begin
      phase   <= phase_nx;
      pad_oe  <= drive_nx.oe;
      pad_out <= drive_nx.val;
      trigger <= avalanche;
    end
  end

  AST_TRIG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> ($past(phase) == PH_ARMED) && !$past(sense_hi)); // R3
  AST_RELEASED_WHILE_SENSING: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETTLE || phase == PH_ARMED) |-> !pad_oe); // R7
  AST_ARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && $past(phase) == PH_SETTLE) |-> $past(sense_hi) && $past(win_done)); // R8
  AST_QUENCH_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_QUENCH) |-> (pad_oe && !pad_out)); // R5
  AST_RECHARGE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECHARGE) |-> (pad_oe && pad_out)); // R6

endmodule

// File: rtl/spad_quench_ctrl.sv
`timescale 1ns/1ps
module spad_quench_ctrl #(
  parameter int CNT_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_in,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] recharge_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             pad_oe,
  output logic             pad_out,
  output logic             trigger
);
  import spq_pkg::*;

  logic             sense_hi;
  logic             win_done;
  logic             win_restart;
  logic [CNT_W-1:0] win_limit;
  phase_t           phase;

  spq_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (sense_hi)
  );

  spq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (win_restart),
    .limit   (win_limit),
    .done    (win_done)
  );

  spq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .sense_hi        (sense_hi),
    .win_done        (win_done),
    .hold_cycles     (hold_cycles),
    .recharge_cycles (recharge_cycles),
    .settle_cycles   (settle_cycles),
    .win_restart     (win_restart),
    .win_limit       (win_limit),
    .phase           (phase),
    .pad_oe          (pad_oe),
    .pad_out         (pad_out),
    .trigger         (trigger)
  );

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !trigger); // R4
  AST_TRIG_WITH_QUENCH: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (pad_oe && !pad_out && $past(!pad_oe))); // R3
  AST_TRIG_NOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pad_oe) |-> !trigger); // R7

endmodule

// File: tb/spad_quench_ctrl_test.sv
`timescale 1ns/1ps
module spad_quench_ctrl_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          node_lvl = 1'b1;
  logic [CW-1:0] hold_c = 8'd5;
  logic [CW-1:0] rech_c = 8'd3;
  logic [CW-1:0] settle_c = 8'd4;
  logic          pad_oe, pad_out, trigger, pad_in;

  int n_tests = 0;
  int n_fail  = 0;
  int trig_total = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Pad node: follows the driver when enabled, else the test-set level
  assign pad_in = pad_oe ? pad_out : node_lvl;

  spad_quench_ctrl #(.CNT_W(CW), .SYNC_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .hold_cycles(hold_c), .recharge_cycles(rech_c), .settle_cycles(settle_c),
    .pad_oe(pad_oe), .pad_out(pad_out), .trigger(trigger)
  );

  always @(negedge clk) if (trigger) trig_total++;

  function automatic int win_len(input int v);
    return v + ((v == 0) ? 1 : 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_arm();
    repeat (win_len(int'(settle_c)) + 6) @(negedge clk);
  endtask

  // One avalanche: measure latency, quench, hold-off and recharge
  task automatic run_event(input string tag, input bit pulse, input bit keep_low);
    int lat, hc, rc, t0;
    t0 = trig_total;
    @(negedge clk);
    node_lvl = 1'b0;
    lat = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (pulse) node_lvl = 1'b1;
      if (trigger) begin lat = i; break; end
    end
    chk({tag, " R2 latency"}, lat, 3);
    chk({tag, " R3 quench with trigger"}, int'(pad_oe && !pad_out), 1);
    if (!keep_low) node_lvl = 1'b1;
    hc = 1;
    forever begin
      @(negedge clk);
      if (hc == 1) chk({tag, " R4 trigger width"}, int'(trigger), 0);
      if (pad_oe && !pad_out) hc++; else break;
      if (hc > 300) break;
    end
    chk({tag, " R5 hold-off length"}, hc, win_len(int'(hold_c)));
    rc = 0;
    while (pad_oe && pad_out && rc < 300) begin rc++; @(negedge clk); end
    chk({tag, " R6 recharge length"}, rc, win_len(int'(rech_c)));
    chk({tag, " R6 released after recharge"}, int'(pad_oe), 0);
    chk({tag, " R4 one trigger"}, trig_total - t0, 1);
  endtask

  task automatic t_reset();
    int hcount;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", int'(pad_oe), 1);
    chk("R1 reset out", int'(pad_out), 1);
    chk("R1 reset trigger", int'(trigger), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    hcount = 0;
    @(negedge clk);
    while (pad_oe && pad_out && hcount < 300) begin hcount++; @(negedge clk); end
    chk("R1 boot charge length", hcount, win_len(int'(rech_c)));
    chk("R1 released after boot", int'(pad_oe), 0);
  endtask

  task automatic t_basic();
    wait_arm();
    run_event("basic", 1'b0, 1'b0);
  endtask

  task automatic t_glitch();
    wait_arm();
    run_event("one-cycle low", 1'b1, 1'b0);
  endtask

  task automatic t_low_unarmed();
    int t0, bad, s;
    s = win_len(int'(settle_c));
    wait_arm();
    run_event("held low", 1'b0, 1'b1);
    t0 = trig_total; bad = 0;
    repeat (30) begin @(negedge clk); if (pad_oe) bad++; end
    chk("R7 no trigger while low unarmed", trig_total - t0, 0);
    chk("R7 pad stays released", bad, 0);
    // High run one short of the window, then low: ignored
    node_lvl = 1'b1;
    repeat (s - 1) @(negedge clk);
    node_lvl = 1'b0;
    t0 = trig_total;
    repeat (20) @(negedge clk);
    chk("R8 short high run ignored", trig_total - t0, 0);
    // High run of exactly the window, then low: detected
    node_lvl = 1'b1;
    repeat (s) @(negedge clk);
    node_lvl = 1'b0;
    t0 = trig_total;
    repeat (10) @(negedge clk);
    chk("R8 full high run arms", trig_total - t0, 1);
    node_lvl = 1'b1;
    while (pad_oe) @(negedge clk);
  endtask

  task automatic t_zero();
    wait_arm();
    hold_c = '0; rech_c = '0; settle_c = '0;
    run_event("R9 zero counts", 1'b0, 1'b0);
  endtask

  task automatic t_long();
    hold_c = 8'd25; rech_c = 8'd4; settle_c = 8'd3;
    wait_arm();
    run_event("long hold", 1'b0, 1'b0);
    wait_arm();
    run_event("back-to-back", 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_glitch();
    t_low_unarmed();
    t_zero();
    t_long();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule